// File: doc/BRIEF.md
# Packed FP64 Predicate Compare Unit

This block compares up to eight pairs of IEEE-754 binary64 values in parallel under one of thirty-two predicates. Each lane first resolves its pair to exactly one of four relations: less, equal, greater or unordered (a NaN on either side). A 5-bit predicate code then selects the set of relations that count as true. The same code also says whether a quiet NaN operand counts as an invalid operation. The result goes out in one of two forms. In vector form, each lane is a 64-bit word of all ones or all zeros. In mask form, each lane gives one bit, and that bit is forced to zero by a per-lane write mask.

A legacy mode narrows the predicate to its low three bits and works on two lanes. In this mode the upper destination lanes are passed through from a prior-value input. In the other modes, the lanes above a selectable lane count are cleared. Lane 0 of the second operand can be broadcast to every lane. Two sticky flags, invalid and denormal, collect exception events from the lanes that take part in the compare. Inputs are taken on an `in_valid` cycle, and results are registered one clock later.

Top module: `fp64_pred_cmp`

## Requirements
- R1: A lane yields unordered when either input is a NaN (exponent all ones, fraction nonzero). Otherwise +0 and -0 are equal, and all other values order by sign and magnitude, with the magnitude order reversed for two negative values.
- R2: Let the truth set be {L,E,G,U} for less, equal, greater and unordered. Code bits 3:0 select the set as follows: 0 {E}, 1 {L}, 2 {L,E}, 3 {U}, 4 {L,G,U}, 5 {E,G,U}, 6 {G,U}, 7 {L,E,G}, 8 {E,U}, 9 {L,U}, A {L,E,U}, B {}, C {L,G}, D {E,G}, E {G}, F {L,E,G,U}. A lane is true when its relation is in the set.
- R3: Outside legacy mode the effective code is `pred[4:0]`, and `pred[7:5]` have no effect. Codes 10h to 1Fh use the same truth set as the code 16 below them.
- R4: In vector mode (`legacy_mode`=0, `mask_mode`=0), lane i of `vec_out` is all ones when the lane is true and i < lane count, and zero otherwise. `mask_out` is zero. `wr_mask` has no effect. Lane count is 2 for `lane_sel`=00, 4 for 01 and 8 for 1x.
- R5: In mask mode (`legacy_mode`=0, `mask_mode`=1), bit i of `mask_out` is 1 only when the lane is true, i < lane count and `wr_mask[i]`=1. `vec_out` is zero.
- R6: In legacy mode, the effective code is `{2'b00, pred[2:0]}`. Lanes 0 and 1 of `vec_out` give the vector result, and lanes 2 and up copy `dest_old`. `mask_out` is zero. `mask_mode`, `lane_sel`, `bcast` and `wr_mask` have no effect.
- R7: With `bcast`=1 outside legacy mode, every lane compares its own `src_a` lane against lane 0 of `src_b`. The other lanes of `src_b` have no effect.
- R8: A lane raises an invalid event when either compared input is a signaling NaN (fraction bit 51 clear). It also raises one when either input is a quiet NaN (fraction bit 51 set) and the code signals. Code bits 3:0 signal when they equal 1, 2, 5, 6, 9, A, D or E, and code bit 4 inverts that.
- R9: A lane raises a denormal event when either compared input is subnormal (exponent zero, fraction nonzero).
- R10: A lane takes part in the compare when it is below the lane count and is either not in mask mode or has its `wr_mask` bit set. Events count only from such lanes. `flag_inv` and `flag_den` are sticky ORs of the events on `in_valid` cycles. `flags_clr` clears them, but the events of the same cycle are still recorded.
- R11: After reset all outputs are zero. `out_valid` follows `in_valid` one cycle later. `vec_out` and `mask_out` update one cycle after an `in_valid` cycle and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Compare request this cycle |
| legacy_mode | input | 1 | Two-lane, 3-bit-code mode with upper-lane pass-through |
| mask_mode | input | 1 | 1 gives bit-mask result, 0 gives 64-bit lane result |
| lane_sel | input | 2 | Lane count: 00 is 2, 01 is 4, 1x is 8 |
| bcast | input | 1 | Use lane 0 of src_b for every lane |
| pred | input | 8 | Predicate code; upper bits reserved |
| wr_mask | input | LANES | Per-lane write mask for mask mode |
| src_a | input | LANES*64 | First operand lanes |
| src_b | input | LANES*64 | Second operand lanes |
| dest_old | input | LANES*64 | Prior destination value for legacy pass-through |
| flags_clr | input | 1 | Clear sticky exception flags |
| out_valid | output | 1 | Result registered this cycle |
| vec_out | output | LANES*64 | All-ones/all-zeros lane results |
| mask_out | output | LANES | Bit-mask result |
| flag_inv | output | 1 | Sticky invalid-operation flag |
| flag_den | output | 1 | Sticky denormal-operand flag |

## Verification
The hardest case to reach from the ports is an exception flag that must stay low even though the vector holds signaling NaNs and subnormals. That happens when every offending value sits in a lane that is masked off, beyond the lane count, or hidden by broadcast. Quiet NaNs add a second trap: they must raise the flag under signaling codes and leave it clear under quiet ones. The stimulus sweeps every ordered pair of a twelve-value set (signed zeros, signed normals, signed subnormals, infinities, both NaN kinds) across all thirty-two codes in both result forms. Directed vectors then plant signaling NaNs and subnormals only in lanes that must not count, under each lane count, write-mask pattern and broadcast setting.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int FP_W         = 64;
  localparam int EXP_W        = 11;
  localparam int FRAC_W       = 52;
  localparam int CODE_W       = 5;
  localparam int REL_W        = 4;
  localparam int LEGACY_LANES = 2;

  // relation one-hot bit positions
  localparam int REL_LT = 0;
  localparam int REL_EQ = 1;
  localparam int REL_GT = 2;
  localparam int REL_UN = 3;

  typedef logic [REL_W-1:0] rel_t;

  typedef struct packed {
    logic            sign;
    logic [FP_W-2:0] mag;
    logic            is_nan;
    logic            is_qnan;
    logic            is_snan;
    logic            is_sub;
    logic            is_zero;
  } fp_class_t;

  function automatic fp_class_t classify(input logic [FP_W-1:0] x);
    fp_class_t c;
    logic exp_ones, exp_zero, frac_nz;
    exp_ones  = &x[FP_W-2 -: EXP_W];
    exp_zero  = ~|x[FP_W-2 -: EXP_W];
    frac_nz   = |x[FRAC_W-1:0];
    c.sign    = x[FP_W-1];
    c.mag     = x[FP_W-2:0];
    c.is_nan  = exp_ones & frac_nz;
    c.is_qnan = c.is_nan & x[FRAC_W-1];
    c.is_snan = c.is_nan & ~x[FRAC_W-1];
    c.is_sub  = exp_zero & frac_nz;
    c.is_zero = exp_zero & ~frac_nz;
    return c;
  endfunction

  // sign-magnitude ordering, NaN -> unordered, signed zeros equal
  function automatic rel_t relate(input fp_class_t a, input fp_class_t b);
    rel_t r;
    logic mag_lt, mag_eq;
    r      = '0;
    mag_lt = a.mag < b.mag;
    mag_eq = a.mag == b.mag;
    if (a.is_nan || b.is_nan)       r[REL_UN] = 1'b1;
    else if (a.is_zero && b.is_zero) r[REL_EQ] = 1'b1;
    else if (a.sign != b.sign) begin
      if (a.sign) r[REL_LT] = 1'b1;
      else        r[REL_GT] = 1'b1;
    end
    else if (mag_eq)                r[REL_EQ] = 1'b1;
    else if (mag_lt ^ a.sign)       r[REL_LT] = 1'b1;
    else                            r[REL_GT] = 1'b1;
    return r;
  endfunction

  // truth set {U,G,E,L} for the low four code bits
  function automatic rel_t pred_truth(input logic [3:0] c);
    rel_t t;
    case (c)
      4'h0: t = 4'b0010;
      4'h1: t = 4'b0001;
      4'h2: t = 4'b0011;
      4'h3: t = 4'b1000;
      4'h4: t = 4'b1101;
      4'h5: t = 4'b1110;
      4'h6: t = 4'b1100;
      4'h7: t = 4'b0111;
      4'h8: t = 4'b1010;
      4'h9: t = 4'b1001;
      4'hA: t = 4'b1011;
      4'hB: t = 4'b0000;
      4'hC: t = 4'b0101;
      4'hD: t = 4'b0110;
      4'hE: t = 4'b0100;
      default: t = 4'b1111;
    endcase
    return t;
  endfunction

  // quiet NaN raises invalid for this code
  function automatic logic pred_signals(input logic [CODE_W-1:0] c);
    logic s;
    case (c[3:0])
      4'h1, 4'h2, 4'h5, 4'h6, 4'h9, 4'hA, 4'hD, 4'hE: s = 1'b1;
      default: s = 1'b0;
    endcase
    return s ^ c[4];
  endfunction

  function automatic int lanes_for(input logic [1:0] sel, input int max_lanes);
    int n;
    case (sel)
      2'b00:   n = 2;
      2'b01:   n = 4;
      default: n = 8;
    endcase
    return (n > max_lanes) ? max_lanes : n;
  endfunction
endpackage

// File: rtl/fpcmp_ctl.sv
module fpcmp_ctl
  import fpcmp_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic              legacy_mode,
  input  logic              mask_mode,
  input  logic [1:0]        lane_sel,
  input  logic              bcast,
  input  logic [7:0]        pred,
  input  logic [LANES-1:0]  wr_mask,
  output logic [CODE_W-1:0] eff_code,
  output logic              eff_sig,
  output logic              use_bcast,
  output logic              mask_sel,
  output logic [LANES-1:0]  lane_act,
  output logic [LANES-1:0]  lane_keep
);
  int   lane_cnt;
  logic unused_rsvd;

  assign unused_rsvd = ^pred[7:CODE_W];

  always_comb begin
    eff_code = legacy_mode ? {2'b00, pred[2:0]} : pred[CODE_W-1:0];
    eff_sig  = pred_signals(eff_code);
    lane_cnt = legacy_mode ? LEGACY_LANES : lanes_for(lane_sel, LANES);
  end

  assign use_bcast = bcast & ~legacy_mode;
  assign mask_sel  = mask_mode & ~legacy_mode;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_act[i] = (i < lane_cnt) && (legacy_mode || !mask_mode || wr_mask[i]);
    if (i >= LEGACY_LANES) begin : g_hi
      assign lane_keep[i] = legacy_mode;
    end else begin : g_lo
      assign lane_keep[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
  import fpcmp_pkg::*;
(
  input  logic [FP_W-1:0] a,
  input  logic [FP_W-1:0] b,
  input  logic [3:0]      code_lo,
  input  logic            sig_pred,
  input  logic            act,
  output rel_t            rel,
  output logic            hit,
  output logic            inv_evt,
  output logic            den_evt
);
  fp_class_t ca, cb;

  always_comb begin
    ca      = classify(a);
    cb      = classify(b);
    rel     = relate(ca, cb);
    hit     = |(rel & pred_truth(code_lo));
    inv_evt = act & (ca.is_snan | cb.is_snan | (sig_pred & (ca.is_qnan | cb.is_qnan)));
    den_evt = act & (ca.is_sub | cb.is_sub);
  end
endmodule

// File: rtl/fp64_pred_cmp.sv
module fp64_pred_cmp
  import fpcmp_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  legacy_mode,
  input  logic                  mask_mode,
  input  logic [1:0]            lane_sel,
  input  logic                  bcast,
  input  logic [7:0]            pred,
  input  logic [LANES-1:0]      wr_mask,
  input  logic [LANES*64-1:0]   src_a,
  input  logic [LANES*64-1:0]   src_b,
  input  logic [LANES*64-1:0]   dest_old,
  input  logic                  flags_clr,
  output logic                  out_valid,
  output logic [LANES*64-1:0]   vec_out,
  output logic [LANES-1:0]      mask_out,
  output logic                  flag_inv,
  output logic                  flag_den
);
  localparam int VW = LANES * FP_W;

  logic [CODE_W-1:0]      eff_code;
  logic                   eff_sig, use_bcast, mask_sel;
  logic [LANES-1:0]       lane_act, lane_keep, lane_hit, lane_inv, lane_den;
  logic [LANES*REL_W-1:0] lane_rel;
  logic [VW-1:0]          vec_nxt;
  logic [LANES-1:0]       mask_nxt;
  logic                   inv_any, den_any;
  logic                   unused_code_hi;

  assign unused_code_hi = eff_code[CODE_W-1];

  fpcmp_ctl #(.LANES(LANES)) u_ctl (
    .legacy_mode (legacy_mode),
    .mask_mode   (mask_mode),
    .lane_sel    (lane_sel),
    .bcast       (bcast),
    .pred        (pred),
    .wr_mask     (wr_mask),
    .eff_code    (eff_code),
    .eff_sig     (eff_sig),
    .use_bcast   (use_bcast),
    .mask_sel    (mask_sel),
    .lane_act    (lane_act),
    .lane_keep   (lane_keep)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [FP_W-1:0] b_sel;
    assign b_sel = use_bcast ? src_b[FP_W-1:0] : src_b[i*FP_W +: FP_W];

    fpcmp_lane u_lane (
      .a        (src_a[i*FP_W +: FP_W]),
      .b        (b_sel),
      .code_lo  (eff_code[3:0]),
      .sig_pred (eff_sig),
      .act      (lane_act[i]),
      .rel      (lane_rel[i*REL_W +: REL_W]),
      .hit      (lane_hit[i]),
      .inv_evt  (lane_inv[i]),
      .den_evt  (lane_den[i])
    );

    assign vec_nxt[i*FP_W +: FP_W] = lane_keep[i] ? dest_old[i*FP_W +: FP_W]
                                   : {FP_W{!mask_sel && lane_act[i] && lane_hit[i]}};
    assign mask_nxt[i] = mask_sel & lane_act[i] & lane_hit[i];
  end

  assign inv_any = |lane_inv;
  assign den_any = |lane_den;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      vec_out   <= '0;
      mask_out  <= '0;
      flag_inv  <= 1'b0;
      flag_den  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        vec_out  <= vec_nxt;
        mask_out <= mask_nxt;
      end
      flag_inv <= (flag_inv & ~flags_clr) | (in_valid & inv_any);
      flag_den <= (flag_den & ~flags_clr) | (in_valid & den_any);
    end
  end
endmodule

// File: rtl/fpcmp_chk.sv
module fpcmp_chk #(
  parameter int LANES = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  legacy_mode,
  input logic                  mask_mode,
  input logic                  flags_clr,
  input logic [LANES-1:0]      wr_mask,
  input logic [LANES*64-129:0] dest_hi,
  input logic                  out_valid,
  input logic [LANES*64-1:0]   vec_out,
  input logic [LANES-1:0]      mask_out,
  input logic                  flag_inv,
  input logic                  flag_den,
  input logic [LANES*4-1:0]    lane_rel,
  input logic [LANES-1:0]      lane_act,
  input logic [LANES-1:0]      lane_inv,
  input logic                  inv_any,
  input logic                  den_any
);
  for (genvar i = 0; i < LANES; i++) begin : g_rel
    // R1
    rel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lane_rel[i*4 +: 4]) == 1);
  end

  // R11
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(vec_out) && $stable(mask_out)));

  // R4
  vec_mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy_mode && !mask_mode) |=> (mask_out == '0));

  // R5
  mask_mode_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy_mode && mask_mode) |=>
      ((vec_out == '0) && ((mask_out & ~$past(wr_mask)) == '0)));

  // R6
  legacy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy_mode) |=>
      ((vec_out[LANES*64-1:128] == $past(dest_hi)) && (mask_out == '0)));

  // R10
  inv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_inv && !flags_clr) |=> flag_inv);

  // R10
  den_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_den && !flags_clr) |=> flag_den);

  // R10
  inv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_inv) |-> $past(in_valid && inv_any));

  // R10
  den_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_den) |-> $past(in_valid && den_any));

  // R10
  idle_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_inv & ~lane_act) == '0);
endmodule

bind fp64_pred_cmp fpcmp_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .legacy_mode (legacy_mode),
  .mask_mode   (mask_mode),
  .flags_clr   (flags_clr),
  .wr_mask     (wr_mask),
  .dest_hi     (dest_old[LANES*64-1:128]),
  .out_valid   (out_valid),
  .vec_out     (vec_out),
  .mask_out    (mask_out),
  .flag_inv    (flag_inv),
  .flag_den    (flag_den),
  .lane_rel    (lane_rel),
  .lane_act    (lane_act),
  .lane_inv    (lane_inv),
  .inv_any     (inv_any),
  .den_any     (den_any)
);

// File: tb/fp64_pred_cmp_test.sv
`timescale 1ns/1ps
module fp64_pred_cmp_test;
  localparam int LANES = 8;
  localparam int VW    = LANES * 64;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0, legacy_mode = 1'b0, mask_mode = 1'b0, bcast = 1'b0, flags_clr = 1'b0;
  logic [1:0]       lane_sel = 2'b00;
  logic [7:0]       pred = 8'h00;
  logic [LANES-1:0] wr_mask = '0;
  logic [VW-1:0]    src_a = '0, src_b = '0, dest_old = '0;
  logic             out_valid, flag_inv, flag_den;
  logic [VW-1:0]    vec_out;
  logic [LANES-1:0] mask_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic             exp_inv = 1'b0, exp_den = 1'b0;
  logic [VW-1:0]    exp_vec = '0;
  logic [LANES-1:0] exp_mask = '0;

  always #10 clk = ~clk;

  fp64_pred_cmp #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .legacy_mode(legacy_mode),
    .mask_mode(mask_mode), .lane_sel(lane_sel), .bcast(bcast), .pred(pred),
    .wr_mask(wr_mask), .src_a(src_a), .src_b(src_b), .dest_old(dest_old),
    .flags_clr(flags_clr), .out_valid(out_valid), .vec_out(vec_out),
    .mask_out(mask_out), .flag_inv(flag_inv), .flag_den(flag_den)
  );

  function automatic logic [63:0] val(input int k);
    case (k)
      0:  return 64'h0000_0000_0000_0000;  // +0
      1:  return 64'h8000_0000_0000_0000;  // -0
      2:  return 64'h3FF0_0000_0000_0000;  // +1
      3:  return 64'hBFF0_0000_0000_0000;  // -1
      4:  return 64'h4000_0000_0000_0000;  // +2
      5:  return 64'hC000_0000_0000_0000;  // -2
      6:  return 64'h0000_0000_0000_0001;  // +subnormal
      7:  return 64'h8000_0000_0000_0001;  // -subnormal
      8:  return 64'h7FF0_0000_0000_0000;  // +inf
      9:  return 64'hFFF0_0000_0000_0000;  // -inf
      10: return 64'h7FF8_0000_0000_0000;  // quiet NaN
      default: return SNAN;
    endcase
  endfunction

  function automatic logic is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic logic is_snan(input logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction
  function automatic logic is_qnan(input logic [63:0] x);
    return is_nan(x) && x[51];
  endfunction
  function automatic logic is_sub(input logic [63:0] x);
    return (x[62:52] == 0) && (x[51:0] != 0);
  endfunction

  // monotone unsigned key for non-NaN values; both zeros share one key
  function automatic logic [63:0] okey(input logic [63:0] x);
    if (x[62:0] == 0) return 64'h8000_0000_0000_0000;
    return x[63] ? ~x : (x | 64'h8000_0000_0000_0000);
  endfunction

  // truth set {U,G,E,L} built from code bit structure
  function automatic logic [3:0] truth_set(input logic [4:0] c);
    logic [3:0] base;
    case (c[1:0])
      2'd0: base = 4'b0010;
      2'd1: base = 4'b0001;
      2'd2: base = 4'b0011;
      default: base = 4'b1000;
    endcase
    return base ^ {4{c[2]}} ^ {c[3], 3'b000};
  endfunction

  function automatic logic pred_true(input logic [63:0] x, input logic [63:0] y, input logic [4:0] c);
    logic [3:0] t;
    t = truth_set(c);
    if (is_nan(x) || is_nan(y)) return t[3];
    if (okey(x) < okey(y)) return t[0];
    if (okey(x) == okey(y)) return t[1];
    return t[2];
  endfunction

  function automatic logic [VW-1:0] grp(input int g, input bit second);
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) begin
      int p;
      p = (g * LANES + i) % 144;
      v[i*64 +: 64] = val(second ? (p % 12) : (p / 12));
    end
    return v;
  endfunction

  task automatic chk_bit(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b", tag, what, got, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s vec_out got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic chk_mask(input string tag, input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s mask_out got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic vld);
    chk_bit(tag, "out_valid", out_valid, vld);
    chk_vec(tag, vec_out, exp_vec);
    chk_mask(tag, mask_out, exp_mask);
    chk_bit(tag, "flag_inv", flag_inv, exp_inv);
    chk_bit(tag, "flag_den", flag_den, exp_den);
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic op(input string tag, input logic leg, input logic msk, input logic [1:0] ls,
                    input logic bc, input logic [7:0] p, input logic [LANES-1:0] wm,
                    input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] old,
                    input logic clr);
    int cnt;
    logic [4:0] c;
    logic e_inv, e_den;
    legacy_mode = leg; mask_mode = msk; lane_sel = ls; bcast = bc; pred = p;
    wr_mask = wm; src_a = a; src_b = b; dest_old = old; flags_clr = clr; in_valid = 1'b1;
    cnt = leg ? 2 : (ls == 2'b00 ? 2 : (ls == 2'b01 ? 4 : 8));
    c = leg ? {2'b00, p[2:0]} : p[4:0];
    e_inv = 1'b0; e_den = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      logic [63:0] av, bv;
      logic act, t;
      av  = a[i*64 +: 64];
      bv  = (bc && !leg) ? b[63:0] : b[i*64 +: 64];
      act = (i < cnt) && (leg || !msk || wm[i]);
      t   = act && pred_true(av, bv, c);
      if (leg && i >= 2) exp_vec[i*64 +: 64] = old[i*64 +: 64];
      else exp_vec[i*64 +: 64] = (t && (leg || !msk)) ? {64{1'b1}} : 64'h0;
      exp_mask[i] = t && msk && !leg;
      if (act) begin
        e_inv = e_inv | is_snan(av) | is_snan(bv) |
                ((c[1] ^ c[0] ^ c[4]) & (is_qnan(av) | is_qnan(bv)));
        e_den = e_den | is_sub(av) | is_sub(bv);
      end
    end
    exp_inv = (clr ? 1'b0 : exp_inv) | e_inv;
    exp_den = (clr ? 1'b0 : exp_den) | e_den;
    @(posedge clk);
    @(negedge clk);
    check_all(tag, 1'b1);
  endtask

  task automatic idle(input string tag, input logic clr);
    in_valid = 1'b0; flags_clr = clr;
    src_a = {LANES{SNAN}}; src_b = {LANES{SNAN}};
    if (clr) begin exp_inv = 1'b0; exp_den = 1'b0; end
    @(posedge clk);
    @(negedge clk);
    check_all(tag, 1'b0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog got hang exp completion");
      finish_run();
    end
  end

  initial begin
    logic [VW-1:0] a, b;
    repeat (3) @(negedge clk);
    // R11 reset state
    check_all("R11 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R11 after reset", 1'b0);

    // R1 R2 R3 R5 R8 R9: mask form, all codes, all value pairs, reserved bits toggled
    for (int code = 0; code < 32; code++)
      for (int g = 0; g < 18; g++)
        op("R1 R2 R3 R5 R8 R9 mask sweep", 1'b0, 1'b1, 2'b10, 1'b0,
           {3'(g), 5'(code)}, '1, grp(g, 0), grp(g, 1), '0, 1'b1);

    // R1 R2 R4 R8: vector form, wr_mask cleared must not matter
    for (int code = 0; code < 32; code++)
      for (int g = 0; g < 18; g++)
        op("R1 R2 R4 R8 vector sweep", 1'b0, 1'b0, 2'b11, 1'b0,
           {3'(7 - g % 8), 5'(code)}, 8'(g * 29), grp(g, 0), grp(g, 1), '0, 1'b1);

    // R6 R3: legacy, upper code bits and other controls set to show no effect
    for (int code = 0; code < 8; code++)
      for (int g = 0; g < 18; g++)
        op("R6 R3 legacy", 1'b1, 1'b1, 2'b00, 1'b1, {3'b110, 2'(g), 3'(code)}, '0,
           grp(g, 0), grp(g, 1), {LANES{64'(g + 1) * 64'h0101_0101_0101_0101}}, 1'b1);

    // R4 R5 R10: lane count, with signaling NaNs and subnormals in lanes 2 and up
    for (int ls = 0; ls < 4; ls++)
      for (int m = 0; m < 2; m++) begin
        for (int i = 0; i < LANES; i++) begin
          a[i*64 +: 64] = (i >= 2) ? SNAN : val(2);
          b[i*64 +: 64] = (i >= 4) ? val(6) : val(3);
        end
        op("R4 R5 R10 lane count", 1'b0, 1'(m), 2'(ls), 1'b0, 8'h0F, '1, a, b, '0, 1'b1);
        op("R4 R5 R10 lane count LT", 1'b0, 1'(m), 2'(ls), 1'b0, 8'h11, '1, b, a, '0, 1'b1);
      end

    // R7: broadcast, other src_b lanes hold signaling NaNs
    for (int code = 0; code < 32; code++)
      for (int k = 0; k < 12; k++) begin
        b = {LANES{SNAN}};
        b[63:0] = val(k);
        op("R7 broadcast", 1'b0, 1'(code % 2), 2'b10, 1'b1, 8'(code), '1,
           grp(k + code, 0), b, '0, 1'b1);
      end

    // R5 R10: write mask patterns, offending values only in masked-off lanes
    for (int k = 0; k < 32; k++) begin
      logic [LANES-1:0] wm;
      wm = 8'(k * 37 + 5);
      a = grp(k % 18, 1);
      b = grp((k + 5) % 18, 0);
      for (int i = 0; i < LANES; i++)
        if (!wm[i]) begin
          a[i*64 +: 64] = SNAN;
          b[i*64 +: 64] = val(7);
        end else begin
          a[i*64 +: 64] = is_nan(a[i*64 +: 64]) || is_sub(a[i*64 +: 64]) ? val(4) : a[i*64 +: 64];
          b[i*64 +: 64] = is_nan(b[i*64 +: 64]) || is_sub(b[i*64 +: 64]) ? val(3) : b[i*64 +: 64];
        end
      op("R5 R10 write mask", 1'b0, 1'b1, 2'b10, 1'b0, 8'h0F, wm, a, b, '0, 1'b1);
      op("R5 R10 write mask GE", 1'b0, 1'b1, 2'b10, 1'b0, 8'h1D, wm, a, b, '0, 1'b1);
    end

    // R10 R11: sticky flags, hold while idle, clear, clear with same-cycle event
    a = {LANES{val(2)}};
    b = {LANES{val(3)}};
    a[64 +: 64] = SNAN;
    b[0 +: 64]  = val(6);
    op("R10 sticky set", 1'b0, 1'b0, 2'b10, 1'b0, 8'h00, '1, a, b, '0, 1'b1);
    op("R10 sticky keep", 1'b0, 1'b0, 2'b10, 1'b0, 8'h0E, '1, {LANES{val(2)}}, {LANES{val(3)}}, '0, 1'b0);
    idle("R10 R11 idle hold", 1'b0);
    idle("R10 R11 idle clear", 1'b1);
    op("R10 clear with event", 1'b0, 1'b1, 2'b00, 1'b0, 8'h01, '1, a, b, '0, 1'b1);
    op("R8 quiet code quiet NaN", 1'b0, 1'b1, 2'b10, 1'b0, 8'h00, '1,
       {LANES{val(10)}}, {LANES{val(2)}}, '0, 1'b1);
    op("R8 signaling code quiet NaN", 1'b0, 1'b1, 2'b10, 1'b0, 8'h10, '1,
       {LANES{val(10)}}, {LANES{val(2)}}, '0, 1'b1);
    idle("R11 final idle", 1'b0);

    finish_run();
  end
endmodule